// File: doc/BRIEF.md
# Dual Interval Timer with Overflow Status

This block holds the two 8-bit interval timers of an FM sound generator's timer section. Software reaches it through four byte-wide host ports. One port pair latches a register address and the other carries data. Each timer counts upward from a programmed preload value. It steps once per tick of its own rate. When the count rolls past 0xFF, the timer reloads from its preload and raises an overflow flag, unless software has masked that flag. A status port reports both flags together with an "any overflow" summary bit.

Two static mode pins set the behaviour. `native_mode` chooses between the extended address map and the legacy address map. `fast_start` chooses whether a newly started timer takes its first step on the write itself, or one full tick period later. Tick timing is derived from the system clock by a prescaler inside each timer. The timer 1 period is `CLKS_PER_80US` clocks. The timer 2 period is four times that. The host path is a plain register interface: a write happens in any cycle where `host_wr` is high, and reads are combinational from `host_port`. There is no valid/ready handshake and no back-pressure.

Top module: `fm_timer_pair`

## Requirements
- R1: After reset both flags are clear (status reads 0x00), both preloads and the control value read back 0x00, and both timers are stopped.
- R2: Native map (`native_mode`=1): a port 0 write sets address bits 7:0, and a port 2 write sets address bits 10:8 from data bits 2:0. Only port 1 is a data port, and port 3 writes are ignored. After the address is ANDed with 0x5FF, 0x402 selects the timer 1 preload, 0x403 the timer 2 preload and 0x404 control. Any other address is latched only.
- R3: Legacy map (`native_mode`=0): a port 0 write latches address {0,data} and a port 2 write latches 0x100|data. Ports 1 and 3 are both data ports. After the address is ANDed with 0x1FF, 0x002, 0x003 and 0x004 select timer 1 preload, timer 2 preload and control.
- R4: Port 0 reads status: bit 6 is the timer 1 flag, bit 5 is the timer 2 flag, bit 7 is their OR, and the other bits are 0. Port 1 reads back the selected preload or control register, or 0x00 when none is selected. Ports 2 and 3 read 0xFF.
- R5: While running, each tick increments the counter modulo 256. On wrap to zero the counter reloads from its preload and an overflow occurs. The timer 1 tick period is CLKS_PER_80US clocks and the timer 2 period is 4 times that. A flag becomes visible one clock after the wrapping tick.
- R6: With `fast_start`=0, a started timer loads its preload and takes its first tick CLKS_PER_80US×ratio clocks after the control write.
- R7: With `fast_start`=1, a started timer takes its first tick in the control write cycle itself. A preload of 0xFF therefore overflows at once.
- R8: An overflow sets a flag only if the stored control value has that timer's mask bit clear. Bit 6 masks timer 1 and bit 5 masks timer 2.
- R9: A control write with bit 7 set clears both flags and changes nothing else. The stored control value and the running timers are untouched.
- R10: A control write with bit 7 clear stores the value. A timer whose start bit is set (bit 0 for timer 1, bit 1 for timer 2) restarts from its preload with a fresh tick phase. A timer whose start bit is clear stops and has its flag cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| native_mode | input | 1 | 1 selects the extended address map, 0 the legacy map |
| fast_start | input | 1 | 1 makes a started timer tick immediately |
| host_wr | input | 1 | Write strobe, one write per cycle |
| host_port | input | 2 | Host port number for write and read |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_port` (combinational) |

## Verification
The bench samples the status port on the exact clock edge of each first overflow, in both start modes and for both tick rates. A design that is off by one prescaler step, or that confuses the immediate and delayed starts, shows the flag one period early or late. It checks that a reset command leaves the control value and the running timer alone, so a design that stores 0x80 as control or halts the timers is caught. It checks that a masked timer never raises its flag, and that stopping a timer clears only that timer's flag. It also checks that the address masks alias 0x602 onto 0x402 in the native map, and that the native map ignores 0x002 and port 3. A decoder that uses the wrong mask or treats the wrong port as a data port therefore corrupts a preload readback.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam int ADDR_W  = 11;
  localparam int TMR_N   = 2;
  localparam int T2_RATIO = 4;

  // control value bit positions
  localparam int CB_CLR   = 7;
  localparam int CB_MASK1 = 6;
  localparam int CB_MASK2 = 5;
  localparam int CB_GO2   = 1;
  localparam int CB_GO1   = 0;

  // status bit positions
  localparam int SB_ANY = 7;
  localparam int SB_T1  = 6;
  localparam int SB_T2  = 5;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PRE1 = 2'd1,
    SEL_PRE2 = 2'd2,
    SEL_CTL  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fmt_host.sv
module fmt_host
  import fmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       native_mode,
  input  logic       host_wr,
  input  logic [1:0] host_port,
  input  logic [7:0] host_wdata,
  output reg_sel_e   sel_o,
  output logic       data_wr_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] masked;
  logic              is_data_port;

  always_comb begin
    if (native_mode) is_data_port = (host_port == 2'd1);
    else             is_data_port = host_port[0];
  end

  assign data_wr_o = host_wr && is_data_port;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (host_wr && !is_data_port) begin
      if (native_mode) begin
        if (host_port == 2'd0)      addr_q[7:0]        <= host_wdata;
        else if (host_port == 2'd2) addr_q[ADDR_W-1:8] <= host_wdata[ADDR_W-9:0];
      end else begin
        addr_q <= {2'b00, host_port[1], host_wdata};
      end
    end
  end

  always_comb begin
    sel_o = SEL_NONE;
    if (native_mode) begin
      masked = addr_q & 11'h5FF;
      case (masked)
        11'h402: sel_o = SEL_PRE1;
        11'h403: sel_o = SEL_PRE2;
        11'h404: sel_o = SEL_CTL;
        default: sel_o = SEL_NONE;
      endcase
    end else begin
      masked = addr_q & 11'h1FF;
      case (masked)
        11'h002: sel_o = SEL_PRE1;
        11'h003: sel_o = SEL_PRE2;
        11'h004: sel_o = SEL_CTL;
        default: sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fmt_timer.sv
module fmt_timer #(
  parameter int PERIOD = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       go_i,
  input  logic       fast_i,
  input  logic [7:0] preload_i,
  output logic       ovf_o
);
  localparam int PW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD - 1);

  logic          run_q;
  logic [PW-1:0] phase_q;
  logic [7:0]    cnt_q;
  logic [7:0]    step_base;
  logic [7:0]    step_val;
  logic          ovf_q;

  assign step_base = load_i ? preload_i : cnt_q;
  assign step_val  = step_base + 8'd1;
  assign ovf_o     = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (load_i) begin
        run_q   <= go_i;
        phase_q <= '0;
        if (go_i) begin
          if (fast_i) begin
            if (step_val == 8'd0) begin
              cnt_q <= preload_i;
              ovf_q <= 1'b1;
            end else begin
              cnt_q <= step_val;
            end
          end else begin
            cnt_q <= preload_i;
          end
        end
      end else if (run_q) begin
        if (phase_q == PH_LAST) begin
          phase_q <= '0;
          if (step_val == 8'd0) begin
            cnt_q <= preload_i;
            ovf_q <= 1'b1;
          end else begin
            cnt_q <= step_val;
          end
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == $past(preload_i)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/fm_timer_pair.sv
module fm_timer_pair
  import fmt_pkg::*;
#(
  parameter int CLKS_PER_80US = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       native_mode,
  input  logic       fast_start,
  input  logic       host_wr,
  input  logic [1:0] host_port,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  reg_sel_e          sel;
  logic              data_wr;
  logic              ctl_wr;
  logic              clr_cmd;
  logic              ctl_load;
  logic [7:0]        pre_q [TMR_N];
  logic [7:0]        ctrl_q;
  logic [TMR_N-1:0]  flag_q;
  logic [TMR_N-1:0]  ovf;

  fmt_host u_host (
    .clk         (clk),
    .rst_n       (rst_n),
    .native_mode (native_mode),
    .host_wr     (host_wr),
    .host_port   (host_port),
    .host_wdata  (host_wdata),
    .sel_o       (sel),
    .data_wr_o   (data_wr)
  );

  assign ctl_wr   = data_wr && (sel == SEL_CTL);
  assign clr_cmd  = ctl_wr && host_wdata[CB_CLR];
  assign ctl_load = ctl_wr && !host_wdata[CB_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q[0] <= '0;
      pre_q[1] <= '0;
      ctrl_q   <= '0;
    end else begin
      if (data_wr && sel == SEL_PRE1) pre_q[0] <= host_wdata;
      if (data_wr && sel == SEL_PRE2) pre_q[1] <= host_wdata;
      if (ctl_load)                   ctrl_q   <= host_wdata;
    end
  end

  for (genvar i = 0; i < TMR_N; i++) begin : g_tmr
    localparam int RATIO = (i == 0) ? 1 : T2_RATIO;
    logic go_bit;
    logic mask_bit;
    assign go_bit   = (i == 0) ? host_wdata[CB_GO1] : host_wdata[CB_GO2];
    assign mask_bit = (i == 0) ? ctrl_q[CB_MASK1]   : ctrl_q[CB_MASK2];

    fmt_timer #(.PERIOD(CLKS_PER_80US * RATIO)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (ctl_load),
      .go_i      (go_bit),
      .fast_i    (fast_start),
      .preload_i (pre_q[i]),
      .ovf_o     (ovf[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)                         flag_q[i] <= 1'b0;
      else if (clr_cmd || (ctl_load && !go_bit)) flag_q[i] <= 1'b0;
      else if (ovf[i] && !mask_bit)       flag_q[i] <= 1'b1;
    end

    // R8
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> !$past(mask_bit));

    // R9
    flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[i]) |-> $past(ctl_wr));
  end

  always_comb begin
    host_rdata = 8'h00;
    case (host_port)
      2'd0: begin
        host_rdata[SB_T1]  = flag_q[0];
        host_rdata[SB_T2]  = flag_q[1];
        host_rdata[SB_ANY] = |flag_q;
      end
      2'd1: begin
        case (sel)
          SEL_PRE1: host_rdata = pre_q[0];
          SEL_PRE2: host_rdata = pre_q[1];
          SEL_CTL:  host_rdata = ctrl_q;
          default:  host_rdata = 8'h00;
        endcase
      end
      default: host_rdata = 8'hFF;
    endcase
  end

  // R9
  clr_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> $stable(ctrl_q));
endmodule

// File: tb/sim_fm_timer_pair.sv
module sim_fm_timer_pair;
  localparam int P = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       native_mode = 1'b1;
  logic       fast_start = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_port = 2'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  fm_timer_pair #(.CLKS_PER_80US(P)) u0 (
    .clk(clk), .rst_n(rst_n), .native_mode(native_mode), .fast_start(fast_start),
    .host_wr(host_wr), .host_port(host_port), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_port = p; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] p, output logic [7:0] v);
    host_port = p;
    #1;
    v = host_rdata;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic nat_addr(input logic [10:0] a);
    wr(2'd2, {5'd0, a[10:8]});
    wr(2'd0, a[7:0]);
  endtask

  task automatic nat_reg(input logic [10:0] a, input logic [7:0] d);
    nat_addr(a);
    wr(2'd1, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); check("R1 status", v, 8'h00);
    nat_addr(11'h404); rd(2'd1, v); check("R1 ctrl", v, 8'h00);
    nat_addr(11'h402); rd(2'd1, v); check("R1 preload1", v, 8'h00);
  endtask

  task automatic t_native_map;
    logic [7:0] v;
    nat_reg(11'h402, 8'hA5); rd(2'd1, v); check("R2 preload1", v, 8'hA5);
    nat_reg(11'h403, 8'h3C); rd(2'd1, v); check("R2 preload2", v, 8'h3C);
    nat_reg(11'h602, 8'h11);
    nat_addr(11'h402); rd(2'd1, v); check("R2 alias 0x602", v, 8'h11);
    nat_reg(11'h002, 8'h77); rd(2'd1, v); check("R4 unselected read", v, 8'h00);
    nat_addr(11'h402); rd(2'd1, v); check("R2 0x002 ignored", v, 8'h11);
    wr(2'd3, 8'h99); rd(2'd1, v); check("R2 port3 ignored", v, 8'h11);
    rd(2'd2, v); check("R4 port2 read", v, 8'hFF);
    rd(2'd3, v); check("R4 port3 read", v, 8'hFF);
  endtask

  task automatic t_delayed_start;
    logic [7:0] v;
    nat_reg(11'h402, 8'hFE);
    nat_reg(11'h404, 8'h01);
    wait_clk(2*P); rd(2'd0, v); check("R6 no flag before wrap", v, 8'h00);
    wait_clk(1);   rd(2'd0, v); check("R4 R6 timer1 flag", v, 8'hC0);
    wr(2'd1, 8'h00); rd(2'd0, v); check("R10 stop clears", v, 8'h00);
  endtask

  task automatic t_timer2;
    logic [7:0] v;
    nat_reg(11'h403, 8'hFF);
    nat_reg(11'h404, 8'h02);
    wait_clk(P+1); rd(2'd0, v); check("R5 timer2 slower", v, 8'h00);
    wait_clk(3*P-1); rd(2'd0, v); check("R5 timer2 before", v, 8'h00);
    wait_clk(1); rd(2'd0, v); check("R5 timer2 flag", v, 8'hA0);
    wr(2'd1, 8'h00); rd(2'd0, v); check("R10 stop timer2", v, 8'h00);
  endtask

  task automatic t_fast;
    logic [7:0] v;
    fast_start = 1'b1;
    nat_reg(11'h402, 8'hFE);
    nat_reg(11'h404, 8'h01);
    wait_clk(P); rd(2'd0, v); check("R7 fast before", v, 8'h00);
    wait_clk(1); rd(2'd0, v); check("R7 fast flag", v, 8'hC0);
    wr(2'd1, 8'h00);
    nat_reg(11'h402, 8'hFF);
    nat_reg(11'h404, 8'h01);
    rd(2'd0, v); check("R7 0xFF not yet", v, 8'h00);
    wait_clk(1); rd(2'd0, v); check("R7 0xFF immediate", v, 8'hC0);
    wr(2'd1, 8'h00);
    fast_start = 1'b0;
  endtask

  task automatic t_mask_and_clear;
    logic [7:0] v;
    nat_reg(11'h402, 8'hFF);
    nat_reg(11'h404, 8'h41);
    wait_clk(3*P+2); rd(2'd0, v); check("R8 masked", v, 8'h00);
    wr(2'd1, 8'h01);
    wait_clk(P); rd(2'd0, v); check("R10 restart phase", v, 8'h00);
    wait_clk(1); rd(2'd0, v); check("R10 restart flag", v, 8'hC0);
    wr(2'd1, 8'h80); rd(2'd0, v); check("R9 clear flags", v, 8'h00);
    rd(2'd1, v); check("R9 ctrl kept", v, 8'h01);
    wait_clk(P+1); rd(2'd0, v); check("R9 timer still runs", v, 8'hC0);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_legacy;
    logic [7:0] v;
    native_mode = 1'b0;
    wr(2'd0, 8'h02); wr(2'd3, 8'h5A); rd(2'd1, v); check("R3 port3 data", v, 8'h5A);
    wr(2'd2, 8'h02); wr(2'd1, 8'h66); rd(2'd1, v); check("R3 0x102 unselected", v, 8'h00);
    wr(2'd0, 8'h02); rd(2'd1, v); check("R3 preload kept", v, 8'h5A);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h04); wr(2'd1, 8'h01);
    wait_clk(P); rd(2'd0, v); check("R3 legacy before", v, 8'h00);
    wait_clk(1); rd(2'd0, v); check("R3 legacy flag", v, 8'hC0);
    wr(2'd1, 8'h00);
    native_mode = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_native_map();
    t_delayed_start();
    t_timer2();
    t_fast();
    t_mask_and_clear();
    t_legacy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule